// File: doc/BRIEF.md
# Sideband Flush and Guaranteed-Access Handshake Controller

This block sits in a host bridge and answers a two-wire, active-low request code from a downstream standard-bus bridge. The requester can ask for nothing, for a drain of only the posted writes headed toward PCI, or for guaranteed access. Guaranteed access drains every buffer and request queue, empties the in-order queue and keeps the host bus owned by the bridge. The code is synchronised into the local clock and then decoded. The controller then raises drain requests toward the buffer logic and watches its empty flags. Once the required drain is done it pulls the active-low acknowledge low.

While any flush is under way or acknowledged, write posting toward PCI is disabled. During guaranteed access the host bus is held. The acknowledge is level-held until the requester withdraws its code. The unused fourth code performs no action and raises an error flag for as long as it is presented. If the code changes to another request while a flush is pending, evaluation restarts with the new request.

Top module: `sbh_top`

## Requirements
- R1: Both request inputs pass through SYNC_STAGES flip-flops (default 2). A change that is stable before a rising edge takes effect on the outputs at rising edge SYNC_STAGES+1 after it, and not before.
- R2: After reset, ack_n=1, post_en=1, pci_drain_req=0, full_drain_req=0, host_bus_hold=0 and rsvd_err=0.
- R3: Code "none" (drain_req_n=1, hold_req_n=1) changes nothing: the block stays idle with post_en=1 and all requests low.
- R4: Code "PCI flush" (drain_req_n=0, hold_req_n=1) raises pci_drain_req and drops post_en, with full_drain_req=0 and host_bus_hold=0.
- R5: Code "guaranteed access" (drain_req_n=0, hold_req_n=0) raises pci_drain_req, full_drain_req and host_bus_hold and drops post_en.
- R6: ack_n falls one edge after the completion flags are seen high during a flush: pci_wbuf_empty alone for a PCI flush, and pci_wbuf_empty, all_bufs_empty and ioq_empty together for guaranteed access. The drain requests drop on the same edge.
- R7: ack_n, post_en=0 and, for guaranteed access, host_bus_hold stay in place while the code is held. They release on the edge after the synchronised code reads "none".
- R8: Code "reserved" (drain_req_n=1, hold_req_n=0) starts no flush and sets rsvd_err while it is the synchronised code. If it arrives during a flush or acknowledge, the block returns to idle.
- R9: If the code changes during a flush or acknowledge to the other flush request, the block restarts evaluation with the new request, applying its drain set and completion rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drain_req_n | input | 1 | Request code bit, active low, asynchronous |
| hold_req_n | input | 1 | Request code bit, active low, asynchronous |
| pci_wbuf_empty | input | 1 | PCI-bound posted write buffers are empty |
| all_bufs_empty | input | 1 | All other buffers and request queues are empty |
| ioq_empty | input | 1 | In-order queue is empty |
| pci_drain_req | output | 1 | Request to drain PCI-bound posted writes |
| full_drain_req | output | 1 | Request to drain all buffers, queues and the in-order queue |
| host_bus_hold | output | 1 | Keep ownership of the host bus |
| post_en | output | 1 | Write posting toward PCI allowed |
| ack_n | output | 1 | Active-low acknowledge to the requester |
| rsvd_err | output | 1 | Reserved code currently presented |

## Verification
A request code change reaches the outputs at the third rising edge (SYNC_STAGES+1), and a change in the empty flags during a flush moves the acknowledge one edge later. The directed checks drive inputs on falling edges, count exactly that many rising edges, and sample 1 ns after the last one. They also sample one edge early to show that nothing moves before its due time. A behavioural model in the bench keeps its own delay line for the code and its own state. Its outputs are compared with the design on every falling edge, through random code and flag sequences.

// File: rtl/sbh_pkg.sv
package sbh_pkg;

  // Decoded request; value is {~drain_req_n, ~hold_req_n}
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RSVD = 2'b01,
    CMD_PCI  = 2'b10,
    CMD_FULL = 2'b11
  } sbh_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FLUSH = 2'b01,
    ST_ACK   = 2'b10
  } sbh_state_e;

  function automatic sbh_cmd_e decode_code(input logic drain_n, input logic hold_n);
    return sbh_cmd_e'({~drain_n, ~hold_n});
  endfunction

  function automatic logic is_flush_cmd(input sbh_cmd_e c);
    return (c == CMD_PCI) || (c == CMD_FULL);
  endfunction

  function automatic logic flush_done(input sbh_cmd_e c, input logic pci_e,
                                      input logic all_e, input logic ioq_e);
    case (c)
      CMD_PCI:  return pci_e;
      CMD_FULL: return pci_e & all_e & ioq_e;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sbh_sync.sv
module sbh_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/sbh_decode.sv
module sbh_decode
  import sbh_pkg::*;
(
  input  logic     drain_n_s,
  input  logic     hold_n_s,
  output sbh_cmd_e cmd,
  output logic     cmd_active,
  output logic     cmd_rsvd
);
  always_comb begin
    cmd        = decode_code(drain_n_s, hold_n_s);
    cmd_active = is_flush_cmd(cmd);
    cmd_rsvd   = (cmd == CMD_RSVD);
  end
endmodule

// File: rtl/sbh_ctrl.sv
module sbh_ctrl
  import sbh_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sbh_cmd_e cmd,
  input  logic     cmd_active,
  input  logic     cmd_rsvd,
  input  logic     pci_wbuf_empty,
  input  logic     all_bufs_empty,
  input  logic     ioq_empty,
  output logic     pci_drain_req,
  output logic     full_drain_req,
  output logic     host_bus_hold,
  output logic     post_en,
  output logic     ack_n,
  output logic     rsvd_err
);
  sbh_state_e state_q, state_d;
  sbh_cmd_e   held_q, held_d;
  logic       rsvd_q;

  // Named internal events
  logic done_w;     // required drain finished for the held request
  logic changed_w;  // synchronised code differs from the held request
  logic restart_w;  // changed to another flush request
  logic drop_w;     // changed to none or reserved

  assign done_w    = flush_done(held_q, pci_wbuf_empty, all_bufs_empty, ioq_empty);
  assign changed_w = (cmd != held_q);
  assign restart_w = changed_w && cmd_active;
  assign drop_w    = changed_w && !cmd_active;

  always_comb begin
    state_d = state_q;
    held_d  = held_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_active) begin
          state_d = ST_FLUSH;
          held_d  = cmd;
        end
      end
      ST_FLUSH: begin
        if (restart_w) begin
          held_d = cmd;
        end else if (drop_w) begin
          state_d = ST_IDLE;
          held_d  = CMD_NONE;
        end else if (done_w) begin
          state_d = ST_ACK;
        end
      end
      ST_ACK: begin
        if (restart_w) begin
          state_d = ST_FLUSH;
          held_d  = cmd;
        end else if (drop_w) begin
          state_d = ST_IDLE;
          held_d  = CMD_NONE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        held_d  = CMD_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      held_q  <= CMD_NONE;
      rsvd_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      held_q  <= held_d;
      rsvd_q  <= cmd_rsvd;
    end
  end

  assign pci_drain_req  = (state_q == ST_FLUSH);
  assign full_drain_req = (state_q == ST_FLUSH) && (held_q == CMD_FULL);
  assign host_bus_hold  = (state_q != ST_IDLE) && (held_q == CMD_FULL);
  assign post_en        = (state_q == ST_IDLE);
  assign ack_n          = (state_q != ST_ACK);
  assign rsvd_err       = rsvd_q;

  // R6
  ack_after_pci_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(pci_wbuf_empty));

  // R6
  ack_after_full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ack_n) && host_bus_hold) |-> ($past(all_bufs_empty) && $past(ioq_empty)));

  // R4
  no_post_while_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_drain_req || !ack_n) |-> !post_en);

  // R5
  hold_only_in_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_drain_req |-> (host_bus_hold && pci_drain_req));

  // R8
  rsvd_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_en && cmd_rsvd) |=> post_en);

  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && cmd == CMD_NONE) |=> (ack_n && post_en && !host_bus_hold));

  // R7
  ack_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !changed_w) |=> !ack_n);
endmodule

// File: rtl/sbh_top.sv
module sbh_top
  import sbh_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drain_req_n,
  input  logic hold_req_n,
  input  logic pci_wbuf_empty,
  input  logic all_bufs_empty,
  input  logic ioq_empty,
  output logic pci_drain_req,
  output logic full_drain_req,
  output logic host_bus_hold,
  output logic post_en,
  output logic ack_n,
  output logic rsvd_err
);
  localparam int CODE_W = 2;

  logic [CODE_W-1:0] code_s;
  sbh_cmd_e          cmd;
  logic              cmd_active;
  logic              cmd_rsvd;

  sbh_sync #(.WIDTH(CODE_W), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({drain_req_n, hold_req_n}),
    .q     (code_s)
  );

  sbh_decode u_decode (
    .drain_n_s  (code_s[1]),
    .hold_n_s   (code_s[0]),
    .cmd        (cmd),
    .cmd_active (cmd_active),
    .cmd_rsvd   (cmd_rsvd)
  );

  sbh_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd            (cmd),
    .cmd_active     (cmd_active),
    .cmd_rsvd       (cmd_rsvd),
    .pci_wbuf_empty (pci_wbuf_empty),
    .all_bufs_empty (all_bufs_empty),
    .ioq_empty      (ioq_empty),
    .pci_drain_req  (pci_drain_req),
    .full_drain_req (full_drain_req),
    .host_bus_hold  (host_bus_hold),
    .post_en        (post_en),
    .ack_n          (ack_n),
    .rsvd_err       (rsvd_err)
  );
endmodule

// File: tb/sbh_top_tb_top.sv
`timescale 1ns/1ps
module sbh_top_tb_top;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drain_req_n = 1'b1, hold_req_n = 1'b1;
  logic pci_wbuf_empty = 1'b1, all_bufs_empty = 1'b1, ioq_empty = 1'b1;
  logic pci_drain_req, full_drain_req, host_bus_hold, post_en, ack_n, rsvd_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sbh_top #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .drain_req_n(drain_req_n), .hold_req_n(hold_req_n),
    .pci_wbuf_empty(pci_wbuf_empty), .all_bufs_empty(all_bufs_empty), .ioq_empty(ioq_empty),
    .pci_drain_req(pci_drain_req), .full_drain_req(full_drain_req),
    .host_bus_hold(host_bus_hold), .post_en(post_en), .ack_n(ack_n), .rsvd_err(rsvd_err)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: codes 0 none, 1 reserved, 2 PCI flush, 3 full
  int dly[$];
  int m_phase = 0;   // 0 idle, 1 draining, 2 acknowledged
  int m_req = 0;
  bit m_rsvd = 0;

  function automatic int code_of(logic d_n, logic h_n);
    return ((d_n ? 0 : 2) + (h_n ? 0 : 1));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly = {};
      for (int i = 0; i < SYNC; i++) dly.push_back(0);
      m_phase = 0; m_req = 0; m_rsvd = 0;
    end else begin
      int c;
      bit ok;
      c = dly[0];
      ok = (m_req == 2) ? pci_wbuf_empty :
           (pci_wbuf_empty && all_bufs_empty && ioq_empty);
      if (m_phase == 0) begin
        if (c >= 2) begin m_phase = 1; m_req = c; end
      end else if (c != m_req) begin
        if (c >= 2) begin m_phase = 1; m_req = c; end
        else begin m_phase = 0; m_req = 0; end
      end else if (m_phase == 1 && ok) begin
        m_phase = 2;
      end
      m_rsvd = (c == 1);
      void'(dly.pop_front());
      dly.push_back(code_of(drain_req_n, hold_req_n));
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6", "model ack_n", ack_n, m_phase != 2);
      chk("R4", "model post_en", post_en, m_phase == 0);
      chk("R4", "model pci_drain_req", pci_drain_req, m_phase == 1);
      chk("R5", "model full_drain_req", full_drain_req, m_phase == 1 && m_req == 3);
      chk("R5", "model host_bus_hold", host_bus_hold, m_phase != 0 && m_req == 3);
      chk("R8", "model rsvd_err", rsvd_err, m_rsvd);
    end
  end

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R2", "reset ack_n", ack_n, 1'b1);
    chk("R2", "reset post_en", post_en, 1'b1);
    chk("R2", "reset pci_drain_req", pci_drain_req, 1'b0);
    chk("R2", "reset host_bus_hold", host_bus_hold, 1'b0);
    chk("R2", "reset rsvd_err", rsvd_err, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    edges(5);
    chk("R3", "none post_en", post_en, 1'b1);
    chk("R3", "none pci_drain_req", pci_drain_req, 1'b0);
    chk("R3", "none ack_n", ack_n, 1'b1);

    // PCI flush
    @(negedge clk) begin pci_wbuf_empty = 1'b0; drain_req_n = 1'b0; end
    edges(SYNC);
    chk("R1", "early pci_drain_req", pci_drain_req, 1'b0);
    edges(1);
    chk("R4", "pci_drain_req", pci_drain_req, 1'b1);
    chk("R4", "post_en", post_en, 1'b0);
    chk("R4", "full_drain_req", full_drain_req, 1'b0);
    edges(4);
    chk("R6", "ack before empty", ack_n, 1'b1);
    @(negedge clk) pci_wbuf_empty = 1'b1;
    edges(1);
    chk("R6", "ack after empty", ack_n, 1'b0);
    chk("R6", "drain dropped", pci_drain_req, 1'b0);
    edges(10);
    chk("R7", "ack held", ack_n, 1'b0);
    chk("R7", "posting off while acked", post_en, 1'b0);
    @(negedge clk) drain_req_n = 1'b1;
    edges(SYNC);
    chk("R7", "ack before release", ack_n, 1'b0);
    edges(1);
    chk("R7", "ack released", ack_n, 1'b1);
    chk("R7", "posting back", post_en, 1'b1);

    // Guaranteed access
    @(negedge clk) begin all_bufs_empty = 1'b0; drain_req_n = 1'b0; hold_req_n = 1'b0; end
    edges(SYNC + 1);
    chk("R5", "full_drain_req", full_drain_req, 1'b1);
    chk("R5", "host_bus_hold", host_bus_hold, 1'b1);
    chk("R5", "pci_drain_req", pci_drain_req, 1'b1);
    edges(4);
    chk("R6", "full ack waits", ack_n, 1'b1);
    @(negedge clk) all_bufs_empty = 1'b1;
    edges(1);
    chk("R6", "full ack", ack_n, 1'b0);
    chk("R7", "hold kept while acked", host_bus_hold, 1'b1);
    @(negedge clk) begin drain_req_n = 1'b1; hold_req_n = 1'b1; end
    edges(SYNC + 1);
    chk("R7", "hold released", host_bus_hold, 1'b0);
    chk("R7", "full ack released", ack_n, 1'b1);

    // Reserved code
    @(negedge clk) hold_req_n = 1'b0;
    edges(SYNC + 1);
    chk("R8", "rsvd_err", rsvd_err, 1'b1);
    chk("R8", "no flush", pci_drain_req, 1'b0);
    chk("R8", "posting kept", post_en, 1'b1);
    @(negedge clk) hold_req_n = 1'b1;
    edges(SYNC + 1);
    chk("R8", "rsvd_err cleared", rsvd_err, 1'b0);

    // Restart and abort
    @(negedge clk) begin pci_wbuf_empty = 1'b0; drain_req_n = 1'b0; end
    edges(SYNC + 1);
    chk("R9", "pci flush first", full_drain_req, 1'b0);
    @(negedge clk) hold_req_n = 1'b0;
    edges(SYNC);
    chk("R9", "restart not early", full_drain_req, 1'b0);
    edges(1);
    chk("R9", "restart to full", full_drain_req, 1'b1);
    chk("R9", "restart hold", host_bus_hold, 1'b1);
    @(negedge clk) drain_req_n = 1'b1;
    edges(SYNC + 1);
    chk("R8", "abort to idle", post_en, 1'b1);
    chk("R8", "abort drain", pci_drain_req, 1'b0);
    chk("R8", "abort hold", host_bus_hold, 1'b0);
    @(negedge clk) begin hold_req_n = 1'b1; pci_wbuf_empty = 1'b1; end
    edges(4);

    // Random sequences, checked by the model each cycle
    for (int k = 0; k < 600; k++) begin
      int hold_cyc;
      int r;
      r = $urandom_range(0, 9);
      hold_cyc = $urandom_range(1, 14);
      @(negedge clk) begin
        drain_req_n = (r < 3);
        hold_req_n  = (r < 2) || (r >= 6 && r < 8);
        if (r == 9) hold_req_n = 1'b0;
      end
      for (int j = 0; j < hold_cyc; j++) begin
        @(negedge clk) begin
          pci_wbuf_empty = ($urandom_range(0, 3) != 0);
          all_bufs_empty = ($urandom_range(0, 3) != 0);
          ioq_empty      = ($urandom_range(0, 4) != 0);
        end
      end
    end
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule